// File: doc/BRIEF.md
# Programmable Skew Clock Phase Selector

This block makes four pairs of clock outputs from one fast sampling clock. The sampling clock runs N times faster than the nominal output frequency, so one sampling period is one skew time unit. A two-bit frequency-range select picks N: 44, 26 or 16 cycles per nominal output period. Each output pair has a two-digit function code, and each digit is a three-level symbol. The code picks one of nine functions. It can shift the pair's waveform by a signed number of time units, divide it by two or by four, or invert it. The code tables differ between the two lower pairs and the two upper pairs.

Outputs come from one shared phase counter. The counter runs over a frame of 4N sampling cycles. A sub-counter gives the position inside a nominal period, and a quarter index tells which of the four periods in the frame is current. A skewed output is a shifted tap of the sub-counter. The divided outputs are decoded from the quarter index. Function codes and the range select take effect only at a frame boundary, so a reconfiguration never cuts a pulse short.

A test select bypasses the timebase. In bypass the outputs follow a reference input. Each pair still applies its own divide or invert function, while the signed skews are ignored. The block has no data stream, so there is no valid/ready handshake and no back-pressure. All pins are plain level controls, and every output comes straight from a flop.

Top module: `skew_phase_sel`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) drives all eight outputs low and restarts the frame. The first edge after reset is released produces frame phase 0, the next edge phase 1, and so on, modulo 4N.
- R2: Each three-level symbol is encoded as 00=LOW, 01=MID, 10=HIGH, and 11 is read as MID. The range select gives N=44 for LOW, N=26 for MID and N=16 for HIGH.
- R3: An undivided output has a period of N sampling cycles and is high for exactly N/2 of them.
- R4: Pairs 0 and 1 are always skewed outputs. Their offset in time units is 3·(s1−1)+(s0−1), where s1 is the symbol in `fcode_i[4p+3:4p+2]`, s0 is the symbol in `fcode_i[4p+1:4p]`, and LOW=0, MID=1, HIGH=2. This gives offsets from −4 to +4. An output with offset k is high in the cycles where ((phase − k) mod N) < N/2.
- R5: Pairs 2 and 3 use twice that offset for the seven codes other than LOW-LOW and HIGH-HIGH. This gives offsets of −6, −4, −2, 0, +2, +4 and +6.
- R6: Code HIGH-HIGH on pair 3 gives the complement of the zero-offset waveform.
- R7: Code LOW-LOW on pair 2 or pair 3 gives divide-by-2: high in the second and fourth N-cycle quarters of the frame. Code HIGH-HIGH on pair 2 gives divide-by-4: high in the first two quarters. Both divided waveforms therefore have a falling edge at the same cycle.
- R8: Function codes and the range select are captured only at reset and at the edge that ends a frame. A change at any other time has no effect until the next frame boundary.
- R9: The two outputs of a pair, `q0_o[p]` and `q1_o[p]`, are always identical.
- R10: When the test select is MID or HIGH (any value other than 00), each output is registered from `ref_i` with a delay of one cycle. Skewed outputs follow `ref_i` and ignore their offset. The inverted output follows `~ref_i`. Divide-by-2 and divide-by-4 give bit 0 and bit 1 of a count of `ref_i` rising edges, and that count is cleared by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, one time unit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| range_sel_i | input | 2 | Three-level frequency-range symbol |
| test_sel_i | input | 2 | Three-level bypass select; 00 selects normal operation |
| ref_i | input | 1 | Reference level used in bypass |
| fcode_i | input | 16 | Four function codes; pair p uses bits [4p+3:4p] |
| q0_o | output | 4 | First output of each pair |
| q1_o | output | 4 | Second output of each pair |

## Verification
The bench goes after the wrap of negative offsets below phase zero. A design that got the modulo wrong would clip or stretch the pulses of the −4 and −6 codes.

It also changes codes and the range select in the middle of a frame. A block that applied them at once would shift its outputs early and make runt pulses.

Symbol 11 on both selects must act as MID; a decoder that read it as HIGH would pick the wrong N or offset. The bench also checks that the divide-by-2 and divide-by-4 outputs fall together. In bypass it checks that offsets are ignored and that the reference-edge dividers count from reset.

// File: rtl/skew_pkg.sv
package skew_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10
  } lvl_e;

  typedef enum logic [1:0] {
    FN_SKEW = 2'd0,
    FN_DIV2 = 2'd1,
    FN_DIV4 = 2'd2,
    FN_INV  = 2'd3
  } fn_kind_e;

  typedef struct packed {
    fn_kind_e   kind;
    logic [3:0] ofs;   // two's complement time units
  } pair_cfg_t;

  // The spare encoding reads as the open (middle) level
  function automatic lvl_e lvl_norm(input logic [1:0] sym);
    return (sym == 2'b11) ? LVL_MID : lvl_e'(sym);
  endfunction

  function automatic pair_cfg_t decode_fn(input logic [1:0] s1_raw,
                                          input logic [1:0] s0_raw,
                                          input logic       coarse,
                                          input logic       hh_inv);
    pair_cfg_t r;
    int d1, d0, steps;
    d1    = int'(lvl_norm(s1_raw));
    d0    = int'(lvl_norm(s0_raw));
    steps = 3 * (d1 - 1) + (d0 - 1);
    r.kind = FN_SKEW;
    r.ofs  = 4'(steps);
    if (coarse) begin
      r.ofs = 4'(2 * steps);
      if (d1 == 0 && d0 == 0) begin
        r.kind = FN_DIV2;
        r.ofs  = '0;
      end else if (d1 == 2 && d0 == 2) begin
        r.kind = hh_inv ? FN_INV : FN_DIV4;
        r.ofs  = '0;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/skew_timebase.sv
module skew_timebase
  import skew_pkg::*;
#(
  parameter int N_LOW  = 44,
  parameter int N_MID  = 26,
  parameter int N_HIGH = 16,
  parameter int SW     = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    range_sel,
  output logic [SW-1:0] sub,
  output logic [1:0]    qtr,
  output logic [SW-1:0] n_cur,
  output logic          wrap
);

  logic [SW-1:0] n_pick;
  logic          last_sub;

  always_comb begin
    unique case (lvl_norm(range_sel))
      LVL_LOW:  n_pick = SW'(N_LOW);
      LVL_HIGH: n_pick = SW'(N_HIGH);
      default:  n_pick = SW'(N_MID);
    endcase
  end

  assign last_sub = (sub == n_cur - 1'b1);
  assign wrap     = last_sub && (qtr == 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      sub   <= '0;
      qtr   <= '0;
      n_cur <= n_pick;
    end else if (wrap) begin
      sub   <= '0;
      qtr   <= '0;
      n_cur <= n_pick;
    end else if (last_sub) begin
      sub   <= '0;
      qtr   <= qtr + 2'd1;
    end else begin
      sub   <= sub + 1'b1;
    end
  end

endmodule

// File: rtl/skew_ref_div.sv
module skew_ref_div (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_in,
  output logic [1:0] div_nx
);

  logic       ref_d;
  logic [1:0] div_q;

  // Count reference rising edges; both bits fall together at 3 -> 0
  assign div_nx = div_q + {1'b0, ref_in & ~ref_d};

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_d <= 1'b0;
      div_q <= '0;
    end else begin
      ref_d <= ref_in;
      div_q <= div_nx;
    end
  end

endmodule

// File: rtl/skew_pair_gen.sv
module skew_pair_gen
  import skew_pkg::*;
#(
  parameter int SW     = 6,
  parameter bit COARSE = 1'b0,
  parameter bit HH_INV = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [1:0]    sel_hi,
  input  logic [1:0]    sel_lo,
  input  logic [SW-1:0] sub,
  input  logic [1:0]    qtr,
  input  logic [SW-1:0] n_cur,
  input  logic          test_on,
  input  logic          ref_in,
  input  logic [1:0]    div_nx,
  output logic          q0,
  output logic          q1,
  output fn_kind_e      cfg_kind,
  output logic [3:0]    cfg_ofs
);

  localparam int TW = SW + 2;

  pair_cfg_t            cfg;
  logic [SW-1:0]        half;
  logic signed [TW-1:0] t_raw, t_wrap, n_s;
  logic                 skew_hi, base_hi, nxt;

  always_ff @(posedge clk) begin
    if (load) cfg <= decode_fn(sel_hi, sel_lo, COARSE, HH_INV);
  end

  assign half    = n_cur >> 1;
  assign n_s     = $signed({2'b00, n_cur});
  assign t_raw   = $signed({2'b00, sub}) - $signed({{(TW-4){cfg.ofs[3]}}, cfg.ofs});
  assign base_hi = (sub < half);

  always_comb begin
    if (t_raw < 0)         t_wrap = t_raw + n_s;
    else if (t_raw >= n_s) t_wrap = t_raw - n_s;
    else                   t_wrap = t_raw;
  end

  assign skew_hi = (t_wrap < $signed({2'b00, half}));

  always_comb begin
    unique case (cfg.kind)
      FN_SKEW: nxt = test_on ? ref_in    : skew_hi;
      FN_INV:  nxt = test_on ? ~ref_in   : ~base_hi;
      FN_DIV2: nxt = test_on ? div_nx[0] : qtr[0];
      default: nxt = test_on ? div_nx[1] : ~qtr[1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q0 <= 1'b0;
      q1 <= 1'b0;
    end else begin
      q0 <= nxt;
      q1 <= nxt;
    end
  end

  assign cfg_kind = cfg.kind;
  assign cfg_ofs  = cfg.ofs;

endmodule

// File: rtl/skew_phase_sel.sv
module skew_phase_sel
  import skew_pkg::*;
#(
  parameter int N_LOW  = 44,
  parameter int N_MID  = 26,
  parameter int N_HIGH = 16,
  parameter int PAIRS  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         range_sel_i,
  input  logic [1:0]         test_sel_i,
  input  logic               ref_i,
  input  logic [4*PAIRS-1:0] fcode_i,
  output logic [PAIRS-1:0]   q0_o,
  output logic [PAIRS-1:0]   q1_o
);

  localparam int N_MAX01 = (N_LOW > N_MID) ? N_LOW : N_MID;
  localparam int N_MAX   = (N_MAX01 > N_HIGH) ? N_MAX01 : N_HIGH;
  localparam int SW      = $clog2(N_MAX + 1);

  logic [SW-1:0]               sub, n_cur;
  logic [1:0]                  qtr;
  logic                        wrap, load, test_on;
  logic [1:0]                  div_nx;
  fn_kind_e [PAIRS-1:0]        pair_kind;
  logic [PAIRS-1:0][3:0]       pair_ofs;

  assign load    = rst | wrap;
  assign test_on = (test_sel_i != 2'b00);

  skew_timebase #(
    .N_LOW(N_LOW), .N_MID(N_MID), .N_HIGH(N_HIGH), .SW(SW)
  ) u_tb (
    .clk(clk), .rst(rst), .range_sel(range_sel_i),
    .sub(sub), .qtr(qtr), .n_cur(n_cur), .wrap(wrap)
  );

  skew_ref_div u_rdiv (
    .clk(clk), .rst(rst), .ref_in(ref_i), .div_nx(div_nx)
  );

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam bit COARSE = (p >= 2);
    localparam bit HH_INV = (p >= 3);
    skew_pair_gen #(
      .SW(SW), .COARSE(COARSE), .HH_INV(HH_INV)
    ) u_pair (
      .clk(clk), .rst(rst), .load(load),
      .sel_hi(fcode_i[4*p+3 -: 2]), .sel_lo(fcode_i[4*p+1 -: 2]),
      .sub(sub), .qtr(qtr), .n_cur(n_cur),
      .test_on(test_on), .ref_in(ref_i), .div_nx(div_nx),
      .q0(q0_o[p]), .q1(q1_o[p]),
      .cfg_kind(pair_kind[p]), .cfg_ofs(pair_ofs[p])
    );
  end

endmodule

// File: rtl/skew_phase_sel_chk.sv
module skew_phase_sel_chk
  import skew_pkg::*;
#(
  parameter int SW    = 6,
  parameter int PAIRS = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  ref_i,
  input logic [PAIRS-1:0]      q0_o,
  input logic [PAIRS-1:0]      q1_o,
  input logic                  test_on,
  input logic [SW-1:0]         sub,
  input logic [SW-1:0]         n_cur,
  input logic                  wrap,
  input fn_kind_e [PAIRS-1:0]  pair_kind,
  input logic [PAIRS-1:0][3:0] pair_ofs
);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (q0_o == '0 && q1_o == '0));

  // R9
  pair_match_chk: assert property (@(posedge clk) disable iff (rst)
    q0_o == q1_o);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> ($stable(pair_kind) && $stable(pair_ofs) && $stable(n_cur)));

  // R3
  sub_range_chk: assert property (@(posedge clk) disable iff (rst)
    sub < n_cur);

  // R3
  sub_step_chk: assert property (@(posedge clk) disable iff (rst)
    (sub != n_cur - 1'b1) |=> (sub == SW'($past(sub) + 1'b1)));

  // R7
  div_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(test_on) && !$past(test_on, 2) &&
     pair_kind[2] == FN_DIV4 && $past(pair_kind[2]) == FN_DIV4 &&
     pair_kind[3] == FN_DIV2 && $past(pair_kind[3]) == FN_DIV2 &&
     $fell(q0_o[2])) |-> $fell(q0_o[3]));

  // R6
  inv_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(test_on) && $past(pair_kind[3]) == FN_INV &&
     $past(pair_kind[0]) == FN_SKEW && $past(pair_ofs[0]) == 4'd0)
    |-> (q0_o[3] != q0_o[0]));

  // R4
  zero_align_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(test_on) &&
     $past(pair_kind[0]) == FN_SKEW && $past(pair_ofs[0]) == 4'd0 &&
     $past(pair_kind[1]) == FN_SKEW && $past(pair_ofs[1]) == 4'd0)
    |-> (q0_o[0] == q0_o[1]));

  // R10
  bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(test_on) && $past(pair_kind[0]) == FN_SKEW)
    |-> (q0_o[0] == $past(ref_i)));

endmodule

bind skew_phase_sel skew_phase_sel_chk #(.SW(SW), .PAIRS(PAIRS)) u_chk (
  .clk(clk), .rst(rst), .ref_i(ref_i), .q0_o(q0_o), .q1_o(q1_o),
  .test_on(test_on), .sub(sub), .n_cur(n_cur), .wrap(wrap),
  .pair_kind(pair_kind), .pair_ofs(pair_ofs)
);

// File: tb/skew_phase_sel_tb.sv
module skew_phase_sel_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  range_sel, test_sel;
  logic        ref_i;
  logic [15:0] fcode;
  logic [3:0]  q0, q1;

  int          n_vec = 0, n_bad = 0;
  int          m_ph, m_n, m_dv;
  logic        m_refd;
  logic [15:0] m_code;
  logic [3:0]  exp_q;
  string       exp_tag [4];
  string       ctx = "R1";
  int          hi0 = 0, hi1 = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  skew_phase_sel u_dut (
    .clk(clk), .rst(rst), .range_sel_i(range_sel), .test_sel_i(test_sel),
    .ref_i(ref_i), .fcode_i(fcode), .q0_o(q0), .q1_o(q1)
  );

  function automatic int lvl(input logic [1:0] s);
    return (s == 2'b11) ? 1 : int'(s);
  endfunction

  function automatic int n_of(input logic [1:0] s);
    case (lvl(s))
      0:       return 44;
      1:       return 26;
      default: return 16;
    endcase
  endfunction

  // Expected output bit from the requirement text (R4..R7, R10)
  function automatic logic exp_bit(input int p, input logic [3:0] code,
                                   input int n, input int ph, input logic tst,
                                   input logic rf, input int dvn,
                                   output string tag);
    int d1, d0, st, k, kind, sb, qt, t;
    d1 = lvl(code[3:2]);
    d0 = lvl(code[1:0]);
    st = 3 * (d1 - 1) + (d0 - 1);
    sb = ph % n;
    qt = ph / n;
    k = 0;
    if (p < 2) begin
      kind = 0; k = st; tag = "R4";
    end else if (d1 == 0 && d0 == 0) begin
      kind = 1; tag = "R7";
    end else if (d1 == 2 && d0 == 2) begin
      kind = (p == 2) ? 2 : 3; tag = (p == 2) ? "R7" : "R6";
    end else begin
      kind = 0; k = 2 * st; tag = "R5";
    end
    if (tst) begin
      tag = "R10";
      case (kind)
        0:       return rf;
        3:       return ~rf;
        1:       return dvn[0];
        default: return dvn[1];
      endcase
    end
    case (kind)
      0: begin
        t = (((sb - k) % n) + n) % n;
        return (t < n / 2);
      end
      1:       return (qt % 2 == 1);
      2:       return (qt < 2);
      default: return !(sb < n / 2);
    endcase
  endfunction

  task automatic step();
    int   dvn;
    logic rise;
    @(posedge clk);
    if (rst) begin
      exp_q  = '0;
      m_ph   = 0;
      m_n    = n_of(range_sel);
      m_code = fcode;
      m_dv   = 0;
      m_refd = 1'b0;
      for (int p = 0; p < 4; p++) exp_tag[p] = "R1";
    end else begin
      rise = ref_i & ~m_refd;
      dvn  = (m_dv + int'(rise)) % 4;
      for (int p = 0; p < 4; p++)
        exp_q[p] = exp_bit(p, m_code[4*p +: 4], m_n, m_ph, (test_sel != 2'b00),
                           ref_i, dvn, exp_tag[p]);
      m_dv   = dvn;
      m_refd = ref_i;
      if (m_ph == 4 * m_n - 1) begin
        m_ph   = 0;
        m_n    = n_of(range_sel);
        m_code = fcode;
      end else begin
        m_ph++;
      end
    end
    @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      n_vec++;
      if (q0[p] !== exp_q[p]) begin
        n_bad++;
        $display("FAIL %s/%s pair %0d q0 got %b expected %b at %0t",
                 ctx, exp_tag[p], p, q0[p], exp_q[p], $time);
      end
      n_vec++;
      if (q1[p] !== exp_q[p]) begin
        n_bad++;
        $display("FAIL R9 pair %0d q1 got %b expected %b at %0t",
                 p, q1[p], exp_q[p], $time);
      end
    end
    hi0 += int'(q0[0]);
    hi1 += int'(q0[1]);
  endtask

  task automatic run(input int cnt);
    for (int i = 0; i < cnt; i++) step();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired, got hung run expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5EED_0C1C));
    rst = 1'b1; range_sel = 2'b01; test_sel = 2'b00; ref_i = 1'b0;
    fcode = 16'h5555;
    ctx = "R1";
    run(3);

    // R4 R6 R7: pair0 -4, pair1 +4, pair2 div2, pair3 inverted; N=26
    fcode = 16'hA0A0;
    run(1);
    rst = 1'b0;
    ctx = "R4";
    hi0 = 0; hi1 = 0;
    run(104);
    // R3: 50% duty over four full periods of N=26
    n_vec++;
    if (hi0 != 52) begin
      n_bad++; $display("FAIL R3 pair 0 high count got %0d expected 52", hi0);
    end
    n_vec++;
    if (hi1 != 52) begin
      n_bad++; $display("FAIL R3 pair 1 high count got %0d expected 52", hi1);
    end
    run(208);

    // R8: change mid-frame; pair2 div4, pair3 div2, range LOW
    run(50);
    ctx = "R8";
    fcode = 16'h0A65;
    range_sel = 2'b00;
    run(54 + 3 * 176);

    // R2: symbol 11 reads as MID on range and on codes
    ctx = "R2";
    fcode = 16'h19BC;
    range_sel = 2'b11;
    run(176 + 3 * 104);
    range_sel = 2'b10;
    run(104 + 4 * 64);

    // Random normal-mode stimulus
    ctx = "RND";
    for (int it = 0; it < 60; it++) begin
      fcode = 16'($urandom);
      range_sel = 2'($urandom % 4);
      run($urandom_range(5, 250));
    end

    // R10: bypass, reference toggles randomly, offsets ignored
    ctx = "R10";
    rst = 1'b1; fcode = 16'h1A08; test_sel = 2'b10; ref_i = 1'b0;
    run(1);
    rst = 1'b0;
    for (int i = 0; i < 600; i++) begin
      if ($urandom % 3 == 0) ref_i = ~ref_i;
      step();
    end
    test_sel = 2'b01;
    for (int it = 0; it < 8; it++) begin
      fcode = 16'($urandom);
      for (int i = 0; i < 120; i++) begin
        if ($urandom % 2 == 0) ref_i = ~ref_i;
        step();
      end
    end

    // Back to normal operation
    ctx = "RND";
    test_sel = 2'b00;
    run(400);
    finish_up();
  end

endmodule